// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block sits between a processor core and an external memory bus on which the low address byte and the data byte share one set of pins. The core hands it one request at a time. Each request carries an address, a read or write flag, a program or data space flag, write data, and a flag saying whether the target is on-chip. The block runs a fixed three-phase bus cycle for each request and returns read data with a one-clock done pulse.

In the first phase the block pulses the address strobe low and drives the low address byte on the shared pins. In the second and third phases it asserts the data strobe. For a write it drives the write data on the shared pins. For a read it releases the pins and captures the incoming byte at the end of the third phase. On-chip accesses still pulse the address strobe, but the data strobe stays high and the read byte comes from the on-chip read port.

One control input floats the whole pin group. While the bus is floated, an accepted external request is held until the bus comes back, and on-chip requests run as normal. Before it accepts any request after reset, the block reads two bytes of program space and assembles the start vector from them.

Top module: `mbus_ctrl`

## Requirements
- R1: `bus_as_n` is low for exactly one clock (phase T1) in every bus cycle, on-chip cycles included, and it is high at all other times.
- R2: In T1, `bus_ad_out` carries the low address byte with `bus_ad_oe` high. Through T1, T2 and T3, `bus_ahi` carries the high address byte and `bus_dspace` carries the space flag (1 = data space, 0 = program space). Both are 0 when no cycle runs.
- R3: On an external write, `bus_ds_n` is low in T2 and T3, and `bus_ad_out` carries the write data with `bus_ad_oe` high in both phases.
- R4: On an external read, `bus_ds_n` is low in T2 and T3 and `bus_ad_oe` is low. The value on `bus_ad_in` at the clock edge that ends T3 appears on `rsp_rdata` in the next clock, together with a one-clock `rsp_done` pulse.
- R5: On an on-chip access, `bus_ds_n` stays high for the whole cycle. A read takes its byte from `onchip_rdata` at the edge that ends T3, and a write also ends with a `rsp_done` pulse.
- R6: `bus_rw` (1 = read, 0 = write) is 0 only during T1 to T3 of an external write.
- R7: While `bus_float` is 1, `bus_en` (the pad drive enable for all bus pins) is 0 and `bus_ad_oe` is 0 in that same clock.
- R8: An external request accepted while `bus_float` is 1 starts no cycle (the address strobe stays high) until `bus_float` returns to 0. T1 then follows in the next clock. An on-chip request is not held.
- R9: After reset the block runs two external program-space reads at addresses 0 and 1, with no `rsp_done`. The byte at address 0 becomes the high byte of `boot_vector`. `boot_valid` pulses for one clock when the vector is ready.
- R10: `req_ready` is 1 only when no cycle is running or held and the start-vector reads are done. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write |
| req_dspace | input | 1 | 1 = data space, 0 = program space |
| req_onchip | input | 1 | 1 = target is on-chip |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Read data of the last read |
| onchip_rdata | input | DATA_W | Read byte from on-chip memory |
| bus_float | input | 1 | 1 = float all bus pins |
| boot_valid | output | 1 | Start vector ready pulse |
| boot_vector | output | ADDR_W | Start vector |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_dspace | output | 1 | Space select, 1 = data |
| bus_ahi | output | ADDR_W-DATA_W | High address byte |
| bus_ad_out | output | DATA_W | Shared address/data output |
| bus_ad_oe | output | 1 | Drive enable of shared pins |
| bus_ad_in | input | DATA_W | Shared address/data input |
| bus_en | output | 1 | Drive enable of all bus pins |

## Verification
The bench targets the exact sampling edge of a read. It changes `bus_ad_in` between T2 and T3, so a design that captures one phase early returns the wrong byte. It checks that the data strobe stays high on on-chip cycles and that the read/write line stays high on on-chip writes, since a design that ignores the on-chip flag would drive real bus writes. It holds an external request behind a floated bus and checks that no address strobe appears and that the request still completes afterwards, which exposes both a lost request and a cycle run on floated pins. It also checks the byte order of the start vector and checks that the boot reads raise no done pulse.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_HOLD = 3'd1,
      PH_T1   = 3'd2,
      PH_T2   = 3'd3,
      PH_T3   = 3'd4
   } phase_e;

   function automatic logic ph_active(input phase_e p);
      return (p == PH_T1) || (p == PH_T2) || (p == PH_T3);
   endfunction

   function automatic logic ph_data(input phase_e p);
      return (p == PH_T2) || (p == PH_T3);
   endfunction

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
   import mbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_dspace,
   input  logic              req_onchip,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              bus_float,
   input  logic              boot_pend,
   input  logic [ADDR_W-1:0] boot_addr,
   output phase_e            phase,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              cur_write,
   output logic              cur_dspace,
   output logic              cur_onchip,
   output logic              cur_boot,
   output logic [DATA_W-1:0] cur_wdata,
   output logic              req_ready,
   output logic              cyc_end
);

   phase_e nxt_phase;
   logic   take_boot;
   logic   take_req;

   assign req_ready = (phase == PH_IDLE) && !boot_pend;
   assign take_boot = (phase == PH_IDLE) && boot_pend;
   assign take_req  = req_ready && req_valid;
   assign cyc_end   = (phase == PH_T3);

   always_comb begin
      nxt_phase = phase;
      case (phase)
         PH_IDLE: begin
            if (take_boot) begin
               nxt_phase = bus_float ? PH_HOLD : PH_T1;
            end else if (take_req) begin
               nxt_phase = (bus_float && !req_onchip) ? PH_HOLD : PH_T1;
            end
         end
         PH_HOLD: if (!bus_float) nxt_phase = PH_T1;
         PH_T1:   nxt_phase = PH_T2;
         PH_T2:   nxt_phase = PH_T3;
         PH_T3:   nxt_phase = PH_IDLE;
         default: nxt_phase = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
      end else begin
         phase <= nxt_phase;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr   <= '0;
         cur_write  <= 1'b0;
         cur_dspace <= 1'b0;
         cur_onchip <= 1'b0;
         cur_boot   <= 1'b0;
         cur_wdata  <= '0;
      end else if (take_boot) begin
         cur_addr   <= boot_addr;
         cur_write  <= 1'b0;
         cur_dspace <= 1'b0;
         cur_onchip <= 1'b0;
         cur_boot   <= 1'b1;
         cur_wdata  <= '0;
      end else if (take_req) begin
         cur_addr   <= req_addr;
         cur_write  <= req_write;
         cur_dspace <= req_dspace;
         cur_onchip <= req_onchip;
         cur_boot   <= 1'b0;
         cur_wdata  <= req_wdata;
      end
   end

endmodule

// File: rtl/mbus_boot.sv
module mbus_boot #(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int VEC_BASE = 0,
   parameter bit HI_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_end,
   input  logic              cur_boot,
   input  logic [DATA_W-1:0] cap_byte,
   output logic              boot_pend,
   output logic [ADDR_W-1:0] boot_addr,
   output logic              boot_valid,
   output logic [ADDR_W-1:0] boot_vector
);

   localparam int VEC_W = 2 * DATA_W;
   localparam logic [1:0] STEPS = 2'd2;

   logic [1:0]        step;
   logic [DATA_W-1:0] first_q;
   logic [VEC_W-1:0]  joined;

   assign boot_pend = (step != STEPS);
   assign boot_addr = ADDR_W'(VEC_BASE) + ADDR_W'(step);

   generate
      if (HI_FIRST) begin : g_hi_first
         assign joined = {first_q, cap_byte};
      end else begin : g_lo_first
         assign joined = {cap_byte, first_q};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step        <= '0;
         first_q     <= '0;
         boot_valid  <= 1'b0;
         boot_vector <= '0;
      end else begin
         boot_valid <= 1'b0;
         if (cyc_end && cur_boot) begin
            step <= step + 2'd1;
            if (step == 2'd0) begin
               first_q <= cap_byte;
            end else begin
               boot_valid  <= 1'b1;
               boot_vector <= joined[ADDR_W-1:0];
            end
         end
      end
   end

endmodule

// File: rtl/mbus_pins.sv
module mbus_pins
   import mbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  phase_e                   phase,
   input  logic [ADDR_W-1:0]        cur_addr,
   input  logic                     cur_write,
   input  logic                     cur_dspace,
   input  logic                     cur_onchip,
   input  logic [DATA_W-1:0]        cur_wdata,
   input  logic                     bus_float,
   output logic                     bus_as_n,
   output logic                     bus_ds_n,
   output logic                     bus_rw,
   output logic                     bus_dspace,
   output logic [ADDR_W-DATA_W-1:0] bus_ahi,
   output logic [DATA_W-1:0]        bus_ad_out,
   output logic                     bus_ad_oe,
   output logic                     bus_en
);

   localparam int HI_W = ADDR_W - DATA_W;

   logic active;
   logic data_ph;
   logic ext_wr;
   logic oe_raw;

   assign active  = ph_active(phase);
   assign data_ph = ph_data(phase);
   assign ext_wr  = cur_write && !cur_onchip;

   assign bus_as_n   = (phase != PH_T1);
   assign bus_ds_n   = !(data_ph && !cur_onchip);
   assign bus_rw     = !(active && ext_wr);
   assign bus_dspace = active && cur_dspace;
   assign bus_ahi    = active ? cur_addr[ADDR_W-1 -: HI_W] : '0;
   assign bus_en     = !bus_float;

   assign oe_raw    = (phase == PH_T1) || (data_ph && ext_wr);
   assign bus_ad_oe = oe_raw && !bus_float;

   always_comb begin
      bus_ad_out = '0;
      if (phase == PH_T1) begin
         bus_ad_out = cur_addr[DATA_W-1:0];
      end else if (data_ph && ext_wr) begin
         bus_ad_out = cur_wdata;
      end
   end

endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
   import mbus_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 8,
   parameter int VEC_BASE = 0,
   parameter bit HI_FIRST = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic                     req_write,
   input  logic                     req_dspace,
   input  logic                     req_onchip,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     rsp_done,
   output logic [DATA_W-1:0]        rsp_rdata,
   input  logic [DATA_W-1:0]        onchip_rdata,
   input  logic                     bus_float,
   output logic                     boot_valid,
   output logic [ADDR_W-1:0]        boot_vector,
   output logic                     bus_as_n,
   output logic                     bus_ds_n,
   output logic                     bus_rw,
   output logic                     bus_dspace,
   output logic [ADDR_W-DATA_W-1:0] bus_ahi,
   output logic [DATA_W-1:0]        bus_ad_out,
   output logic                     bus_ad_oe,
   input  logic [DATA_W-1:0]        bus_ad_in,
   output logic                     bus_en
);

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("mbus_ctrl: DATA_W must be at least 1");
      end
      if (ADDR_W <= DATA_W || ADDR_W > 2 * DATA_W) begin : g_bad_addr
         $error("mbus_ctrl: ADDR_W must lie above DATA_W and at most 2*DATA_W");
      end
      if (VEC_BASE < 0 || VEC_BASE + 1 >= (1 << ADDR_W)) begin : g_bad_base
         $error("mbus_ctrl: VEC_BASE out of address range");
      end
   endgenerate

   phase_e            phase;
   logic [ADDR_W-1:0] cur_addr;
   logic              cur_write;
   logic              cur_dspace;
   logic              cur_onchip;
   logic              cur_boot;
   logic [DATA_W-1:0] cur_wdata;
   logic              cyc_end;
   logic              boot_pend;
   logic [ADDR_W-1:0] boot_addr;
   logic [DATA_W-1:0] cap_byte;

   assign cap_byte = cur_onchip ? onchip_rdata : bus_ad_in;

   mbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .req_write  (req_write),
      .req_dspace (req_dspace),
      .req_onchip (req_onchip),
      .req_wdata  (req_wdata),
      .bus_float  (bus_float),
      .boot_pend  (boot_pend),
      .boot_addr  (boot_addr),
      .phase      (phase),
      .cur_addr   (cur_addr),
      .cur_write  (cur_write),
      .cur_dspace (cur_dspace),
      .cur_onchip (cur_onchip),
      .cur_boot   (cur_boot),
      .cur_wdata  (cur_wdata),
      .req_ready  (req_ready),
      .cyc_end    (cyc_end)
   );

   mbus_boot #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .VEC_BASE (VEC_BASE),
      .HI_FIRST (HI_FIRST)
   ) boot_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cyc_end     (cyc_end),
      .cur_boot    (cur_boot),
      .cap_byte    (cap_byte),
      .boot_pend   (boot_pend),
      .boot_addr   (boot_addr),
      .boot_valid  (boot_valid),
      .boot_vector (boot_vector)
   );

   mbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) pins_i (
      .phase      (phase),
      .cur_addr   (cur_addr),
      .cur_write  (cur_write),
      .cur_dspace (cur_dspace),
      .cur_onchip (cur_onchip),
      .cur_wdata  (cur_wdata),
      .bus_float  (bus_float),
      .bus_as_n   (bus_as_n),
      .bus_ds_n   (bus_ds_n),
      .bus_rw     (bus_rw),
      .bus_dspace (bus_dspace),
      .bus_ahi    (bus_ahi),
      .bus_ad_out (bus_ad_out),
      .bus_ad_oe  (bus_ad_oe),
      .bus_en     (bus_en)
   );

   // R4 / R5: response registered at the edge that ends T3
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_done  <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_done <= cyc_end && !cur_boot;
         if (cyc_end && !cur_boot && !cur_write) begin
            rsp_rdata <= cap_byte;
         end
      end
   end

endmodule

// File: rtl/mbus_ctrl_chk.sv
module mbus_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic rsp_done,
   input logic boot_valid,
   input logic bus_as_n,
   input logic bus_ds_n,
   input logic bus_rw,
   input logic bus_ad_oe,
   input logic bus_en
);

   assert_as_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_as_n |=> bus_as_n);

   assert_addr_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_as_n && bus_en) |-> bus_ad_oe);

   assert_ds_after_as_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_ds_n) |-> $past(!bus_as_n));

   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   assert_rw_at_t1_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_rw) |-> !bus_as_n);

   assert_float_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_en |-> !bus_ad_oe);

   assert_boot_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      boot_valid |=> !boot_valid);

   assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (bus_as_n && bus_ds_n && bus_rw));

endmodule

bind mbus_ctrl mbus_ctrl_chk chk_i (.*);

// File: tb/mbus_ctrl_tb_top.sv
module mbus_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          req_write = 1'b0;
   logic          req_dspace = 1'b0;
   logic          req_onchip = 1'b0;
   logic [DW-1:0] req_wdata = '0;
   logic          rsp_done;
   logic [DW-1:0] rsp_rdata;
   logic [DW-1:0] onchip_rdata = 8'h11;
   logic          bus_float = 1'b0;
   logic          boot_valid;
   logic [AW-1:0] boot_vector;
   logic          bus_as_n, bus_ds_n, bus_rw, bus_dspace, bus_ad_oe, bus_en;
   logic [AW-DW-1:0] bus_ahi;
   logic [DW-1:0] bus_ad_out;
   logic [DW-1:0] bus_ad_in = 8'hEE;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbus_ctrl dut_i (.*);

   int checks = 0;
   int fails = 0;

   function automatic logic [7:0] ext_byte(input logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hC3;
   endfunction

   function automatic logic [7:0] chip_byte(input logic [15:0] a);
      return ~a[7:0] ^ a[15:8];
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   typedef struct {
      logic [15:0] addr;
      logic        wr;
      logic        ds;
      logic        oc;
      logic        boot;
      logic [7:0]  wd;
   } op_t;

   op_t         boot_q[$];
   op_t         cur = '{16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0};
   int          m_ph = 0;   // 0 idle, 1 held, 2 T1, 3 T2, 4 T3
   logic        m_done = 1'b0;
   logic [7:0]  m_rdata = 8'h0;
   logic        m_bv = 1'b0;
   logic [15:0] m_vec = 16'h0;
   logic [7:0]  m_first = 8'h0;
   bit          acc_seen = 1'b0;
   bit          cmp_on = 1'b0;

   task automatic load_boot();
      boot_q.delete();
      boot_q.push_back('{16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0});
      boot_q.push_back('{16'h0001, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0});
   endtask

   always @(posedge clk) begin
      logic [7:0] got;
      if (!rst_n) begin
         m_ph = 0; m_done = 0; m_rdata = 0; m_bv = 0; m_vec = 0; m_first = 0;
         load_boot();
      end else begin
         m_done = 0;
         m_bv = 0;
         case (m_ph)
            0: begin
               if (boot_q.size() > 0) begin
                  cur = boot_q.pop_front();
                  m_ph = bus_float ? 1 : 2;
               end else if (req_valid) begin
                  cur = '{req_addr, req_write, req_dspace, req_onchip, 1'b0, req_wdata};
                  acc_seen = 1;
                  m_ph = (bus_float && !req_onchip) ? 1 : 2;
               end
            end
            1: if (!bus_float) m_ph = 2;
            2: m_ph = 3;
            3: m_ph = 4;
            default: begin
               got = cur.oc ? onchip_rdata : bus_ad_in;
               if (cur.boot) begin
                  if (cur.addr == 16'h0) m_first = got;
                  else begin m_vec = {m_first, got}; m_bv = 1; end
               end else begin
                  m_done = 1;
                  if (!cur.wr) m_rdata = got;
               end
               m_ph = 0;
            end
         endcase
      end
   end

   // per-clock comparison and external memory drive
   always @(negedge clk) begin
      logic act, dph, ewr, oe_raw;
      #1;
      act = (m_ph >= 2);
      dph = (m_ph == 3) || (m_ph == 4);
      ewr = cur.wr && !cur.oc;
      oe_raw = (m_ph == 2) || (dph && ewr);
      if (cmp_on) begin
         chk("R1 as_n", bus_as_n, m_ph != 2);
         chk("R2 ahi", bus_ahi, act ? cur.addr[15:8] : 8'h0);
         chk("R2 dspace", bus_dspace, act && cur.ds);
         if (m_ph == 2 && !bus_float) chk("R2 t1 addr", bus_ad_out, cur.addr[7:0]);
         if (dph && ewr && !bus_float) chk("R3 wdata", bus_ad_out, cur.wd);
         chk(cur.oc ? "R5 ds_n" : "R3 ds_n", bus_ds_n, !(dph && !cur.oc));
         chk("R6 rw", bus_rw, !(act && ewr));
         chk("R7 bus_en", bus_en, !bus_float);
         chk("R7 ad_oe", bus_ad_oe, oe_raw && !bus_float);
         chk("R4 done", rsp_done, m_done);
         chk("R4 rdata", rsp_rdata, m_rdata);
         chk("R9 boot_valid", boot_valid, m_bv);
         if (m_bv) chk("R9 vector", boot_vector, m_vec);
         chk("R10 ready", req_ready, (m_ph == 0) && (boot_q.size() == 0));
      end
      bus_ad_in = (m_ph == 4 && !cur.oc && !cur.wr) ? ext_byte(cur.addr)
                : (m_ph == 3 ? 8'hEE : 8'h5A);
      onchip_rdata = (m_ph == 4 && cur.oc) ? chip_byte(cur.addr) : 8'h11;
   end

   task automatic issue(input logic [15:0] a, input logic wr, input logic ds,
                        input logic oc, input logic [7:0] wd);
      @(negedge clk);
      req_valid = 1; req_addr = a; req_write = wr; req_dspace = ds;
      req_onchip = oc; req_wdata = wd; acc_seen = 0;
      do @(negedge clk); while (!acc_seen);
      req_valid = 0;
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!rsp_done);
      #2;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 40000);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_run();
   end

   initial begin
      int low_cnt;
      int wait_cnt;
      load_boot();
      repeat (3) @(negedge clk);
      #2;
      chk("R1 reset as_n", bus_as_n, 1'b1);
      chk("R10 reset ready", req_ready, 1'b0);
      chk("R4 reset done", rsp_done, 1'b0);
      cmp_on = 1;
      rst_n = 1;

      // R9: boot sequence and byte order
      do @(negedge clk); while (!boot_valid);
      #2;
      chk("R9 vector hi byte from addr 0", boot_vector, {ext_byte(16'h0), ext_byte(16'h1)});

      // R4: external reads in both spaces
      issue(16'h12A5, 1'b0, 1'b1, 1'b0, 8'h00);
      wait_done();
      chk("R4 ext read data", rsp_rdata, ext_byte(16'h12A5));
      issue(16'hF00F, 1'b0, 1'b0, 1'b0, 8'h00);
      wait_done();
      chk("R4 ext read program", rsp_rdata, ext_byte(16'hF00F));

      // R3 / R6: external write leaves rdata alone
      issue(16'h3407, 1'b1, 1'b1, 1'b0, 8'h9C);
      wait_done();
      chk("R3 write keeps rdata", rsp_rdata, ext_byte(16'hF00F));

      // R5: on-chip read and write
      issue(16'h0050, 1'b0, 1'b1, 1'b1, 8'h00);
      wait_done();
      chk("R5 onchip read data", rsp_rdata, chip_byte(16'h0050));
      issue(16'h00A0, 1'b1, 1'b1, 1'b1, 8'h77);
      wait_done();
      chk("R5 onchip write done", rsp_done, 1'b1);

      // R10: back-to-back requests
      issue(16'h8001, 1'b0, 1'b1, 1'b0, 8'h00);
      issue(16'h8002, 1'b0, 1'b1, 1'b0, 8'h00);
      wait_done();
      chk("R10 second read", rsp_rdata, ext_byte(16'h8002));

      // R8: on-chip not held while floated
      @(negedge clk);
      bus_float = 1;
      issue(16'h0033, 1'b0, 1'b0, 1'b1, 8'h00);
      wait_done();
      chk("R8 onchip while floated", rsp_rdata, chip_byte(16'h0033));

      // R8: external request held, then completes
      issue(16'h4455, 1'b0, 1'b1, 1'b0, 8'h00);
      low_cnt = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         #2;
         if (!bus_as_n) low_cnt++;
         if (rsp_done) low_cnt++;
      end
      chk("R8 no cycle while floated", low_cnt, 0);
      chk("R7 pads released", {bus_en, bus_ad_oe}, 2'b00);
      bus_float = 0;
      wait_cnt = 0;
      do begin @(negedge clk); wait_cnt++; end while (!rsp_done && wait_cnt < 20);
      #2;
      chk("R8 held read completes", rsp_rdata, ext_byte(16'h4455));
      chk("R8 held read latency", wait_cnt, 4);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule